// File: doc/BRIEF.md
# Receive Frame Filter with Acknowledgement Request

This block stands behind the receive parser of a low-rate wireless radio and decides the fate of every received frame. For each frame it takes the parsed frame type, the acknowledgement-request flag, the destination addressing mode, the destination PAN identifier and address, and two quality flags: header length valid and checksum valid. From these it decides whether the frame is kept for the host and whether an end-of-frame interrupt is raised. It also decides whether the destination address belongs to this node, which raises an address-match interrupt. Last, it decides whether the transmitter must send an acknowledgement.

Four mode bits shape these decisions: upload of reserved frame types, address filtering of reserved frame types, promiscuous reception, and suppression of acknowledgements. The node's own PAN identifier, short address and 64-bit extended address are plain inputs. The mode bits are captured on the start-of-frame strobe and held for that frame. A later change on those pins only affects the next frame.

Frames arrive as strobes with no back-pressure. The block can take a start-of-frame and an end-of-frame strobe on every cycle, so it behaves as a stream sink whose ready is always high. The frame fields must be stable in the cycle that carries the end-of-frame strobe. If both strobes fall in the same cycle, the decision uses the mode bits captured at the previous start-of-frame, and the new capture applies to the next frame.

Top module: `rxf_filter_top`

## Requirements
- R1: After reset, every output is 0: the three pulse outputs, the keep level and the checksum-valid level.
- R2: The frame type is a 3-bit code. Code 0 is beacon, 1 is data, 2 is acknowledgement and 3 is command; codes 4 to 7 (bit 2 set) are reserved. The destination mode is a 2-bit code: 0 means no address, 1 is reserved, 2 is a 16-bit short address (bits 15:0 of the address input) and 3 is a 64-bit extended address.
- R3: A frame type other than reserved or acknowledgement passes the address filter only in these cases. With mode 2, the PAN must equal the node's PAN or 0xFFFF, and the short address must equal the node's short address or 0xFFFF. With mode 3, the PAN must match in the same way and the extended address must equal the node's. With mode 0, only beacons pass. Outside promiscuous mode, such a frame is kept, with an end-of-frame interrupt, only if it passes the filter and its checksum is valid.
- R4: Outside promiscuous mode with reserved upload off, a reserved-type frame is dropped: no end-of-frame interrupt and keep is 0.
- R5: With reserved upload on and reserved filtering off, a reserved-type frame is kept, with an end-of-frame interrupt, exactly when its checksum is valid.
- R6: With both reserved upload and reserved filtering on, a reserved-type frame goes through the R3 address filter. A pass raises the address-match interrupt, and the frame is kept only when it passes and its checksum is valid.
- R7: An acknowledgement is requested only when all of these hold: the frame passes the address filter, its checksum is valid and its ack-request flag is set. It is never requested when ack suppression is on, for an acknowledgement frame, or for a short destination of 0xFFFF.
- R8: In promiscuous mode, every frame with a valid header length is kept and raises the end-of-frame interrupt, whatever the filter or checksum result. Address match and acknowledgement still follow R3, R6 and R7.
- R9: The checksum-valid level takes the checksum flag of every frame with a valid header length and holds its value otherwise.
- R10: A frame with an invalid header length raises no pulse and sets keep to 0.
- R11: The end-of-frame interrupt, address-match interrupt and acknowledgement request are single-cycle pulses. They appear only in the cycle after an end-of-frame strobe. Keep is a level updated at every end-of-frame, and an end-of-frame interrupt implies keep.
- R12: Mode bits are taken at the start-of-frame strobe; their value at the end-of-frame strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame strobe, captures the mode bits |
| eof_i | input | 1 | End-of-frame strobe, frame fields valid |
| phr_ok_i | input | 1 | Header length field valid |
| fcs_ok_i | input | 1 | Frame checksum valid |
| frm_type_i | input | 3 | Frame type code |
| frm_ackreq_i | input | 1 | Acknowledgement-request flag of the frame |
| frm_dmode_i | input | 2 | Destination address mode |
| dst_pan_i | input | 16 | Destination PAN identifier |
| dst_addr_i | input | 64 | Destination address (short in bits 15:0) |
| mode_rsv_upload_i | input | 1 | Reserved-type upload enable |
| mode_rsv_filter_i | input | 1 | Reserved-type address filtering enable |
| mode_promisc_i | input | 1 | Promiscuous reception |
| mode_ack_off_i | input | 1 | Suppress acknowledgement requests |
| node_pan_i | input | 16 | Node PAN identifier |
| node_short_i | input | 16 | Node short address |
| node_ext_i | input | 64 | Node extended address |
| irq_end_o | output | 1 | End-of-frame interrupt pulse |
| irq_amatch_o | output | 1 | Address-match interrupt pulse |
| crc_ok_o | output | 1 | Checksum-valid status level |
| keep_o | output | 1 | Frame kept for upload (level) |
| ack_req_o | output | 1 | Acknowledgement request pulse |

## Verification
The main sweep covers all sixteen mode combinations, all eight frame-type codes and all four destination modes. For each, it varies the PAN (own, broadcast, foreign), the address (own, broadcast, foreign), the checksum, the ack-request flag and the header flag. The PAN and address choices separate filter passes from failures, and broadcast destinations from own ones. The checksum and header flags separate the promiscuous paths from the normal ones. Every frame has its mode pins inverted at the end-of-frame strobe, so a block that reads the live pins instead of the captured bits gives wrong results under the sweep. The strobe cycle itself is also sampled, which shows whether a pulse comes early or not at all.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [2:0] FT_BEACON = 3'd0;
  localparam logic [2:0] FT_DATA   = 3'd1;
  localparam logic [2:0] FT_ACK    = 3'd2;
  localparam logic [2:0] FT_CMD    = 3'd3;

  localparam logic [1:0] DM_NONE  = 2'd0;
  localparam logic [1:0] DM_RSVD  = 2'd1;
  localparam logic [1:0] DM_SHORT = 2'd2;
  localparam logic [1:0] DM_EXT   = 2'd3;

  typedef struct packed {
    logic rsv_upload;
    logic rsv_filter;
    logic promisc;
    logic ack_off;
  } rx_mode_t;

  typedef struct packed {
    logic fire_end;
    logic fire_match;
    logic keep;
    logic want_ack;
  } verdict_t;

endpackage

// File: rtl/rxf_mode_latch.sv
module rxf_mode_latch
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  rx_mode_t mode_in,
  output rx_mode_t mode_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_held <= '0;
    else if (capture) mode_held <= mode_in;
  end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int EXT_W   = 64,
  parameter int LANE_W  = 16
) (
  input  logic [2:0]         ftype,
  input  logic [1:0]         dmode,
  input  logic [PAN_W-1:0]   dst_pan,
  input  logic [EXT_W-1:0]   dst_addr,
  input  logic [PAN_W-1:0]   node_pan,
  input  logic [SHORT_W-1:0] node_short,
  input  logic [EXT_W-1:0]   node_ext,
  output logic               rule_ok,
  output logic               dst_bcast
);
  localparam int NLANE = (EXT_W + LANE_W - 1) / LANE_W;
  localparam int PADW  = NLANE * LANE_W;

  logic [PADW-1:0]  dst_pad, own_pad;
  logic [NLANE-1:0] lane_eq;
  logic             pan_ok, short_ok, ext_ok;
  logic [SHORT_W-1:0] dst_short;

  assign dst_pad   = PADW'(dst_addr);
  assign own_pad   = PADW'(node_ext);
  assign dst_short = dst_addr[SHORT_W-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_eq[g] = dst_pad[g*LANE_W +: LANE_W] == own_pad[g*LANE_W +: LANE_W];
  end

  assign ext_ok    = &lane_eq;
  assign pan_ok    = (dst_pan == node_pan) || (dst_pan == {PAN_W{1'b1}});
  assign short_ok  = (dst_short == node_short) || (dst_short == {SHORT_W{1'b1}});
  assign dst_bcast = (dmode == DM_SHORT) && (dst_short == {SHORT_W{1'b1}});

  always_comb begin
    unique case (dmode)
      DM_NONE:  rule_ok = (ftype == FT_BEACON);
      DM_SHORT: rule_ok = pan_ok && short_ok;
      DM_EXT:   rule_ok = pan_ok && ext_ok;
      default:  rule_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  rx_mode_t   mode,
  input  logic [2:0] ftype,
  input  logic       ackreq,
  input  logic       phr_ok,
  input  logic       fcs_ok,
  input  logic       rule_ok,
  input  logic       dst_bcast,
  output verdict_t   verdict
);
  logic is_rsv, is_ack, eligible, hit, keep_norm;

  always_comb begin
    is_rsv    = ftype[2];
    is_ack    = (ftype == FT_ACK);
    eligible  = is_rsv ? (mode.rsv_upload && mode.rsv_filter) : !is_ack;
    hit       = phr_ok && eligible && rule_ok;
    keep_norm = is_rsv ? (mode.rsv_upload && (!mode.rsv_filter || hit)) : hit;

    verdict.keep       = phr_ok && (mode.promisc || (fcs_ok && keep_norm));
    verdict.fire_end   = verdict.keep;
    verdict.fire_match = hit;
    verdict.want_ack   = hit && fcs_ok && ackreq && !mode.ack_off && !dst_bcast && !is_ack;
  end
endmodule

// File: rtl/rxf_filter_top.sv
module rxf_filter_top
  import rxf_pkg::*;
#(
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int EXT_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               phr_ok_i,
  input  logic               fcs_ok_i,
  input  logic [2:0]         frm_type_i,
  input  logic               frm_ackreq_i,
  input  logic [1:0]         frm_dmode_i,
  input  logic [PAN_W-1:0]   dst_pan_i,
  input  logic [EXT_W-1:0]   dst_addr_i,
  input  logic               mode_rsv_upload_i,
  input  logic               mode_rsv_filter_i,
  input  logic               mode_promisc_i,
  input  logic               mode_ack_off_i,
  input  logic [PAN_W-1:0]   node_pan_i,
  input  logic [SHORT_W-1:0] node_short_i,
  input  logic [EXT_W-1:0]   node_ext_i,
  output logic               irq_end_o,
  output logic               irq_amatch_o,
  output logic               crc_ok_o,
  output logic               keep_o,
  output logic               ack_req_o
);
  rx_mode_t mode_live, mode_frame;
  verdict_t verdict;
  logic     rule_ok, dst_bcast;

  assign mode_live = '{rsv_upload: mode_rsv_upload_i, rsv_filter: mode_rsv_filter_i,
                       promisc: mode_promisc_i, ack_off: mode_ack_off_i};

  rxf_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .capture(sof_i),
    .mode_in(mode_live), .mode_held(mode_frame)
  );

  rxf_addr_match #(.PAN_W(PAN_W), .SHORT_W(SHORT_W), .EXT_W(EXT_W)) u_match (
    .ftype(frm_type_i), .dmode(frm_dmode_i), .dst_pan(dst_pan_i), .dst_addr(dst_addr_i),
    .node_pan(node_pan_i), .node_short(node_short_i), .node_ext(node_ext_i),
    .rule_ok(rule_ok), .dst_bcast(dst_bcast)
  );

  rxf_decide u_decide (
    .mode(mode_frame), .ftype(frm_type_i), .ackreq(frm_ackreq_i),
    .phr_ok(phr_ok_i), .fcs_ok(fcs_ok_i), .rule_ok(rule_ok),
    .dst_bcast(dst_bcast), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_end_o    <= 1'b0;
      irq_amatch_o <= 1'b0;
      ack_req_o    <= 1'b0;
      keep_o       <= 1'b0;
      crc_ok_o     <= 1'b0;
    end else begin
      irq_end_o    <= eof_i && verdict.fire_end;
      irq_amatch_o <= eof_i && verdict.fire_match;
      ack_req_o    <= eof_i && verdict.want_ack;
      if (eof_i) keep_o <= verdict.keep;
      if (eof_i && phr_ok_i) crc_ok_o <= fcs_ok_i;
    end
  end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic eof_i,
  input logic phr_ok_i,
  input logic irq_end_o,
  input logic irq_amatch_o,
  input logic crc_ok_o,
  input logic keep_o,
  input logic ack_req_o
);
  assert_end_after_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_o |-> $past(eof_i));
  assert_match_after_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_amatch_o |-> $past(eof_i));
  assert_end_implies_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_o |-> keep_o);
  assert_ack_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (irq_amatch_o && crc_ok_o));
  assert_crc_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eof_i) |-> $stable(crc_ok_o));
  assert_bad_header_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eof_i && !phr_ok_i) |-> (!irq_end_o && !irq_amatch_o && !ack_req_o && !keep_o));
endmodule

bind rxf_filter_top rxf_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .phr_ok_i(phr_ok_i),
  .irq_end_o(irq_end_o), .irq_amatch_o(irq_amatch_o), .crc_ok_o(crc_ok_o),
  .keep_o(keep_o), .ack_req_o(ack_req_o)
);

// File: tb/sim_rxf_filter_top.sv
module sim_rxf_filter_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_i = 0, eof_i = 0, phr_ok_i = 0, fcs_ok_i = 0, frm_ackreq_i = 0;
  logic [2:0] frm_type_i = '0;
  logic [1:0] frm_dmode_i = '0;
  logic [15:0] dst_pan_i = '0;
  logic [63:0] dst_addr_i = '0;
  logic m_up = 0, m_flt = 0, m_prom = 0, m_off = 0;
  logic [15:0] node_pan_i = 16'h1A2B;
  logic [15:0] node_short_i = 16'h0042;
  logic [63:0] node_ext_i = 64'h0011_2233_4455_6677;
  logic irq_end_o, irq_amatch_o, crc_ok_o, keep_o, ack_req_o;

  int compared = 0, mismatched = 0;
  logic exp_crc = 0;

  always #4 clk = ~clk;

  rxf_filter_top u0 (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .eof_i(eof_i), .phr_ok_i(phr_ok_i),
    .fcs_ok_i(fcs_ok_i), .frm_type_i(frm_type_i), .frm_ackreq_i(frm_ackreq_i),
    .frm_dmode_i(frm_dmode_i), .dst_pan_i(dst_pan_i), .dst_addr_i(dst_addr_i),
    .mode_rsv_upload_i(m_up), .mode_rsv_filter_i(m_flt), .mode_promisc_i(m_prom),
    .mode_ack_off_i(m_off), .node_pan_i(node_pan_i), .node_short_i(node_short_i),
    .node_ext_i(node_ext_i), .irq_end_o(irq_end_o), .irq_amatch_o(irq_amatch_o),
    .crc_ok_o(crc_ok_o), .keep_o(keep_o), .ack_req_o(ack_req_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One frame: start strobe with mode c, end strobe with mode inverted (R12).
  task automatic frame(input logic [3:0] c, input logic [2:0] ft, input logic [1:0] dm,
                       input int psel, input int asel, input logic fcs,
                       input logic ar, input logic phr, input logic [3:0] c_eof);
    logic up, flt, prom, off, rsv, elig, rule, hit, keepn, kp, bc, ack;
    logic [15:0] pan;
    logic [63:0] addr;
    @(negedge clk);
    sof_i = 1; {m_up, m_flt, m_prom, m_off} = c;
    @(negedge clk);
    pan = (psel == 0) ? node_pan_i : (psel == 1) ? 16'hFFFF : 16'h1A2C;
    if (dm == 2'd3)
      addr = (asel == 0) ? node_ext_i : (asel == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : (node_ext_i ^ 64'h1);
    else
      addr = {48'hDEAD_BEEF_0000, (asel == 0) ? node_short_i : (asel == 1) ? 16'hFFFF : 16'h0043};
    sof_i = 0; eof_i = 1; frm_type_i = ft; frm_dmode_i = dm; dst_pan_i = pan;
    dst_addr_i = addr; fcs_ok_i = fcs; frm_ackreq_i = ar; phr_ok_i = phr;
    {m_up, m_flt, m_prom, m_off} = c_eof;
    chk("R11 no end pulse before strobe", irq_end_o, 1'b0);
    chk("R11 no ack pulse before strobe", ack_req_o, 1'b0);
    // Expected model from requirements R2..R10.
    {up, flt, prom, off} = c;
    rsv = ft[2];
    elig = rsv ? (up && flt) : (ft != 3'd2);
    case (dm)
      2'd0: rule = (ft == 3'd0);
      2'd2: rule = (psel != 2) && (asel != 2);
      2'd3: rule = (psel != 2) && (asel == 0);
      default: rule = 1'b0;
    endcase
    hit = phr && elig && rule;
    keepn = rsv ? (up && (!flt || hit)) : hit;
    kp = phr && (prom || (fcs && keepn));
    bc = (dm == 2'd2) && (asel == 1);
    ack = hit && fcs && ar && !off && !bc && (ft != 3'd2);
    if (phr) exp_crc = fcs;
    @(negedge clk);
    eof_i = 0;
    if (!phr) chk("R10 end irq", irq_end_o, 1'b0);
    else if (prom) chk("R8 end irq", irq_end_o, kp);
    else if (rsv && !up) chk("R4 end irq", irq_end_o, kp);
    else if (rsv && !flt) chk("R5 end irq", irq_end_o, kp);
    else if (rsv) chk("R6 end irq", irq_end_o, kp);
    else chk("R3 end irq", irq_end_o, kp);
    chk(rsv ? "R6 address match" : "R3 address match", irq_amatch_o, hit);
    chk("R7 ack request", ack_req_o, ack);
    chk("R11 keep level", keep_o, kp);
    chk("R9 checksum level", crc_ok_o, exp_crc);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 end irq at reset", irq_end_o, 1'b0);
    chk("R1 match at reset", irq_amatch_o, 1'b0);
    chk("R1 ack at reset", ack_req_o, 1'b0);
    chk("R1 keep at reset", keep_o, 1'b0);
    chk("R1 crc at reset", crc_ok_o, 1'b0);
    rst_n = 1'b1;
    // R12 directed: promiscuous only at start, bad checksum, foreign address.
    frame(4'b0010, 3'd1, 2'd2, 2, 2, 1'b0, 1'b0, 1'b1, 4'b0000);
    // R12 directed: ack suppression turned on only at end strobe has no effect.
    frame(4'b0000, 3'd1, 2'd2, 0, 0, 1'b1, 1'b1, 1'b1, 4'b0001);
    // R2 encodings: full sweep over codes and modes.
    for (int c = 0; c < 16; c++)
      for (int ft = 0; ft < 8; ft++)
        for (int dm = 0; dm < 4; dm++)
          for (int ps = 0; ps < 3; ps++)
            for (int as = 0; as < 3; as++)
              for (int k = 0; k < 8; k++)
                frame(4'(c), 3'(ft), 2'(dm), ps, as, k[0], k[1], k[2], ~4'(c));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule